// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

The block keeps a 64-bit count of nanoseconds that moves forward on every tick of its reference clock. Each tick adds a base step set by a three-bit field, plus one. A fine frequency trim lengthens or shortens one tick in every N ticks by one nanosecond, where N is a 42-bit interval and a direction bit selects the sign. Software can place a new absolute time into the counter through two staging words and a separate strobe. It can also request a push event that captures the current time. The running value is driven out on every cycle so that other blocks can use it.

Besides push events, the block reports when bit 31 of the low word changes through counting. A change from 0 to 1 is a half-rollover. A change from 1 to 0 is a rollover. Events leave on a single port as a one-cycle valid pulse with a type code and a 64-bit time stamp. A narrow mode keeps the high word fixed and lets only the low word wrap.

Top module: `ns_timebase`

## Requirements
- R1: After reset the time is 0, no event is output, and every setting is zero, so the counter does not run until it is enabled.
- R2: Write addresses: 0 control, 1 step field, 2 staging low word, 3 staging high word, 4 load strobe, 5 push strobe, 6 interval low word, 7 interval high bits [9:0]. When control bit 0 is clear, the time holds. When it is set, the time gains step+1 ns on each clock edge, where step is the three-bit field at address 1.
- R3: A write to either staging word leaves the time unchanged. A write of 1 in bit 0 at address 4 makes the time equal the staged value {high,low} at that edge, and this takes precedence over counting. A write at address 4 with bit 0 clear has no effect.
- R4: When control bit 5 is set, a carry out of the low word increments the high word. When it is clear, the low word wraps modulo 2^32 and the high word holds.
- R5: With a nonzero interval N, every Nth enabled tick adds step+2 ns if control bit 7 is 0, or step ns if it is 1. All other ticks add step+1.
- R6: An interval of zero turns the trim off, so every tick adds step+1.
- R7: A write of 1 in bit 0 at address 5 produces, after that edge, an event of type 0 that carries the time held just before the edge. The block produces this event whether the counter is enabled or not. A write with bit 0 clear produces no event.
- R8: When counting changes bit 31 of the low word from 0 to 1, the block emits an event of type 2. When counting changes it from 1 to 0, the block emits an event of type 1. Each such event carries the new time and appears in the same cycle as that time. A load never produces one of these events.
- R9: When a push falls on the same edge as a rollover or half-rollover, the push event comes out first. The other event follows on the next cycle with its own time stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one tick per rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| time_o | output | 64 | Current time in nanoseconds |
| evt_valid_o | output | 1 | Event valid, one cycle |
| evt_type_o | output | 4 | Event type: 0 push, 1 rollover, 2 half-rollover |
| evt_time_o | output | 64 | Time stamp of the event |

## Verification
The step-range property assumes that every enabled, non-load tick is a normal counting step. It also assumes that the step field changes only by a register write, which takes effect on the following tick. The bench keeps to this because it measures rates only in windows that contain no load and no setting change. The event properties assume that two edge events never fall on back-to-back ticks. The stimulus holds to this by using steps of a few nanoseconds, so bit 31 of the low word toggles only about every 2^31 ns, except when a load jumps the time, and a load emits nothing.

// File: rtl/ns_timebase_pkg.sv
package ns_timebase_pkg;

  typedef enum logic [2:0] {
    ADDR_CTRL  = 3'd0,
    ADDR_STEP  = 3'd1,
    ADDR_LDLO  = 3'd2,
    ADDR_LDHI  = 3'd3,
    ADDR_LDGO  = 3'd4,
    ADDR_PUSH  = 3'd5,
    ADDR_CORLO = 3'd6,
    ADDR_CORHI = 3'd7
  } reg_addr_e;

  typedef enum logic [3:0] {
    EVT_PUSH = 4'd0,
    EVT_ROLL = 4'd1,
    EVT_HALF = 4'd2
  } evt_type_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_WIDE_BIT = 5;
  localparam int CTRL_DIR_BIT  = 7;

endpackage

// File: rtl/ns_timebase_regs.sv
module ns_timebase_regs
  import ns_timebase_pkg::*;
#(
  parameter int TIME_W    = 64,
  parameter int ADD_W     = 3,
  parameter int CORR_HI_W = 10,
  localparam int HALF_W   = TIME_W / 2,
  localparam int CORR_W   = HALF_W + CORR_HI_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic              en_o,
  output logic              wide_o,
  output logic              dir_o,
  output logic [ADD_W-1:0]  add_o,
  output logic [TIME_W-1:0] stage_o,
  output logic [CORR_W-1:0] corr_o,
  output logic              corr_wr_o,
  output logic              load_o,
  output logic              push_o
);

  reg_addr_e              addr;
  logic [HALF_W-1:0]      stage_lo_q, stage_hi_q, corr_lo_q;
  logic [CORR_HI_W-1:0]   corr_hi_q;

  assign addr = reg_addr_e'(wr_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      wide_o     <= 1'b0;
      dir_o      <= 1'b0;
      add_o      <= '0;
      stage_lo_q <= '0;
      stage_hi_q <= '0;
      corr_lo_q  <= '0;
      corr_hi_q  <= '0;
    end else if (wr_en_i) begin
      case (addr)
        ADDR_CTRL: begin
          en_o   <= wr_data_i[CTRL_EN_BIT];
          wide_o <= wr_data_i[CTRL_WIDE_BIT];
          dir_o  <= wr_data_i[CTRL_DIR_BIT];
        end
        ADDR_STEP:  add_o      <= wr_data_i[ADD_W-1:0];
        ADDR_LDLO:  stage_lo_q <= wr_data_i;
        ADDR_LDHI:  stage_hi_q <= wr_data_i;
        ADDR_CORLO: corr_lo_q  <= wr_data_i;
        ADDR_CORHI: corr_hi_q  <= wr_data_i[CORR_HI_W-1:0];
        default: ;
      endcase
    end
  end

  // strobes act on the write edge itself
  assign load_o    = wr_en_i && (addr == ADDR_LDGO) && wr_data_i[0];
  assign push_o    = wr_en_i && (addr == ADDR_PUSH) && wr_data_i[0];
  assign corr_wr_o = wr_en_i && ((addr == ADDR_CORLO) || (addr == ADDR_CORHI));
  assign stage_o   = {stage_hi_q, stage_lo_q};
  assign corr_o    = {corr_hi_q, corr_lo_q};

endmodule

// File: rtl/ns_timebase_rate.sv
module ns_timebase_rate #(
  parameter int ADD_W   = 3,
  parameter int CORR_W  = 42,
  localparam int STEP_W = ADD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dir_i,
  input  logic [ADD_W-1:0]  add_i,
  input  logic [CORR_W-1:0] corr_i,
  input  logic              restart_i,
  output logic [STEP_W-1:0] step_o
);

  logic [CORR_W-1:0] tick_q;
  logic              active, hit;
  logic [STEP_W-1:0] base;

  assign active = en_i && (corr_i != '0);
  assign hit    = active && (tick_q == corr_i - 1'b1);
  assign base   = {1'b0, add_i} + STEP_W'(1);

  always_comb begin
    step_o = base;
    if (hit) step_o = dir_i ? {1'b0, add_i} : base + STEP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   tick_q <= '0;
    else if (restart_i || !active) tick_q <= '0;
    else if (hit)                  tick_q <= '0;
    else                           tick_q <= tick_q + 1'b1;
  end

endmodule

// File: rtl/ns_timebase_count.sv
module ns_timebase_count #(
  parameter int TIME_W  = 64,
  parameter int STEP_W  = 4,
  localparam int HALF_W = TIME_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wide_i,
  input  logic              load_i,
  input  logic [TIME_W-1:0] stage_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] nxt_o,
  output logic              roll_o,
  output logic              half_o
);

  logic [HALF_W:0]   lo_sum;
  logic [HALF_W-1:0] lo, hi, nxt_lo, nxt_hi;
  logic              counting;

  assign lo       = time_o[HALF_W-1:0];
  assign hi       = time_o[TIME_W-1:HALF_W];
  assign counting = en_i && !load_i;

  always_comb begin
    lo_sum = {1'b0, lo} + {{(HALF_W + 1 - STEP_W){1'b0}}, step_i};
    nxt_lo = lo_sum[HALF_W-1:0];
    nxt_hi = wide_i ? hi + {{(HALF_W - 1){1'b0}}, lo_sum[HALF_W]} : hi;
  end

  assign nxt_o  = {nxt_hi, nxt_lo};
  assign roll_o = counting &&  lo[HALF_W-1] && !nxt_lo[HALF_W-1];
  assign half_o = counting && !lo[HALF_W-1] &&  nxt_lo[HALF_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     time_o <= '0;
    else if (load_i) time_o <= stage_i;
    else if (en_i)   time_o <= nxt_o;
  end

endmodule

// File: rtl/ns_timebase_evt.sv
module ns_timebase_evt
  import ns_timebase_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              roll_i,
  input  logic              half_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic [TIME_W-1:0] nxt_i,
  output logic              valid_o,
  output evt_type_e         type_o,
  output logic [TIME_W-1:0] stamp_o
);

  logic              pend_q;
  evt_type_e         pend_type_q;
  logic [TIME_W-1:0] pend_time_q;
  logic              edge_w;
  evt_type_e         edge_type;

  assign edge_w    = roll_i || half_i;
  assign edge_type = roll_i ? EVT_ROLL : EVT_HALF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      type_o      <= EVT_PUSH;
      stamp_o     <= '0;
      pend_q      <= 1'b0;
      pend_type_q <= EVT_PUSH;
      pend_time_q <= '0;
    end else begin
      valid_o <= 1'b0;
      if (push_i) begin
        valid_o <= 1'b1;
        type_o  <= EVT_PUSH;
        stamp_o <= time_i;
        if (edge_w) begin
          pend_q      <= 1'b1;
          pend_type_q <= edge_type;
          pend_time_q <= nxt_i;
        end
      end else if (pend_q) begin
        valid_o <= 1'b1;
        type_o  <= pend_type_q;
        stamp_o <= pend_time_q;
        pend_q  <= edge_w;
        if (edge_w) begin
          pend_type_q <= edge_type;
          pend_time_q <= nxt_i;
        end
      end else if (edge_w) begin
        valid_o <= 1'b1;
        type_o  <= edge_type;
        stamp_o <= nxt_i;
      end
    end
  end

endmodule

// File: rtl/ns_timebase.sv
module ns_timebase
  import ns_timebase_pkg::*;
#(
  parameter int TIME_W    = 64,
  parameter int ADD_W     = 3,
  parameter int CORR_HI_W = 10,
  localparam int HALF_W   = TIME_W / 2,
  localparam int CORR_W   = HALF_W + CORR_HI_W,
  localparam int STEP_W   = ADD_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [HALF_W-1:0] wr_data_i,
  output logic [TIME_W-1:0] time_o,
  output logic              evt_valid_o,
  output logic [3:0]        evt_type_o,
  output logic [TIME_W-1:0] evt_time_o
);

  logic              en_w, wide_w, dir_w, load_w, push_w, corr_wr_w;
  logic [ADD_W-1:0]  add_w;
  logic [TIME_W-1:0] stage_w, nxt_w;
  logic [CORR_W-1:0] corr_w;
  logic [STEP_W-1:0] step_w;
  logic              roll_w, half_w;
  evt_type_e         evt_type_w;

  ns_timebase_regs #(.TIME_W(TIME_W), .ADD_W(ADD_W), .CORR_HI_W(CORR_HI_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en_w), .wide_o(wide_w), .dir_o(dir_w), .add_o(add_w),
    .stage_o(stage_w), .corr_o(corr_w), .corr_wr_o(corr_wr_w),
    .load_o(load_w), .push_o(push_w)
  );

  ns_timebase_rate #(.ADD_W(ADD_W), .CORR_W(CORR_W)) u_rate (
    .clk_i, .rst_ni, .en_i(en_w), .dir_i(dir_w), .add_i(add_w),
    .corr_i(corr_w), .restart_i(corr_wr_w), .step_o(step_w)
  );

  ns_timebase_count #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_count (
    .clk_i, .rst_ni, .en_i(en_w), .wide_i(wide_w), .load_i(load_w),
    .stage_i(stage_w), .step_i(step_w), .time_o(time_o), .nxt_o(nxt_w),
    .roll_o(roll_w), .half_o(half_w)
  );

  ns_timebase_evt #(.TIME_W(TIME_W)) u_evt (
    .clk_i, .rst_ni, .push_i(push_w), .roll_i(roll_w), .half_i(half_w),
    .time_i(time_o), .nxt_i(nxt_w), .valid_o(evt_valid_o),
    .type_o(evt_type_w), .stamp_o(evt_time_o)
  );

  assign evt_type_o = evt_type_w;

endmodule

// File: rtl/ns_timebase_chk.sv
module ns_timebase_chk #(
  parameter int TIME_W  = 64,
  parameter int ADD_W   = 3,
  localparam int HALF_W = TIME_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              wide_i,
  input logic              load_i,
  input logic              push_i,
  input logic [ADD_W-1:0]  add_i,
  input logic [TIME_W-1:0] stage_i,
  input logic [TIME_W-1:0] time_i,
  input logic              evt_valid_i,
  input logic [3:0]        evt_type_i,
  input logic [TIME_W-1:0] evt_time_i
);

  logic              cnt_prev_q;
  logic [HALF_W-1:0] lo_prev_q, delta, lo_min, lo_max;
  logic [ADD_W-1:0]  add_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_prev_q <= 1'b0;
      lo_prev_q  <= '0;
      add_prev_q <= '0;
    end else begin
      cnt_prev_q <= en_i && !load_i;
      lo_prev_q  <= time_i[HALF_W-1:0];
      add_prev_q <= add_i;
    end
  end

  assign delta  = time_i[HALF_W-1:0] - lo_prev_q;
  assign lo_min = {{(HALF_W - ADD_W){1'b0}}, add_prev_q};
  assign lo_max = lo_min + HALF_W'(2);

  a_r2_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(time_i));

  a_r3_load_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (time_i == $past(stage_i)));

  a_r4_narrow_high_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wide_i && !load_i) |=> (time_i[TIME_W-1:HALF_W] == $past(time_i[TIME_W-1:HALF_W])));

  a_r5_step_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_prev_q |-> ((delta >= lo_min) && (delta <= lo_max)));

  a_r7_push_stamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (evt_valid_i && (evt_type_i == 4'd0) && (evt_time_i == $past(time_i))));

  a_r8_known_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_i |-> (evt_type_i <= 4'd2));

endmodule

bind ns_timebase ns_timebase_chk #(.TIME_W(TIME_W), .ADD_W(ADD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_w), .wide_i(wide_w), .load_i(load_w),
  .push_i(push_w), .add_i(add_w), .stage_i(stage_w), .time_i(time_o),
  .evt_valid_i(evt_valid_o), .evt_type_i(evt_type_o), .evt_time_i(evt_time_o)
);

// File: tb/ns_timebase_test.sv
module ns_timebase_test;

  localparam logic [2:0] A_CTRL = 3'd0, A_STEP = 3'd1, A_LDLO = 3'd2, A_LDHI = 3'd3,
                         A_LDGO = 3'd4, A_PUSH = 3'd5, A_CORLO = 3'd6, A_CORHI = 3'd7;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [63:0] time_o, evt_time_o;
  logic        evt_valid_o;
  logic [3:0]  evt_type_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [67:0] exp_q[$];

  ns_timebase uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rate(input int n, input logic [63:0] exp, input string req);
    logic [63:0] t0;
    t0 = time_o;
    repeat (n) @(negedge clk_i);
    chk((time_o - t0) == exp, req, {4'd0, time_o - t0}, {4'd0, exp});
  endtask

  task automatic push_evt();
    exp_q.push_back({4'd0, time_o});
    wr(A_PUSH, 32'h1);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && evt_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected event", {evt_type_o, evt_time_o}, '0);
      end else begin
        logic [67:0] e;
        e = exp_q.pop_front();
        chk({evt_type_o, evt_time_o} == e, "R7/R8/R9 event", {evt_type_o, evt_time_o}, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(time_o == 64'd0 && !evt_valid_o, "R1 reset state", {3'd0, evt_valid_o, time_o}, '0);
    rst_ni = 1'b1;
    rate(5, 64'd0, "R1 idle after reset");

    // R3: staging alone has no effect, strobe loads
    wr(A_LDHI, 32'h1);
    wr(A_LDLO, 32'h100);
    chk(time_o == 64'd0, "R3 staging no effect", {4'd0, time_o}, '0);
    wr(A_LDGO, 32'h1);
    chk(time_o == 64'h1_0000_0100, "R3 load", {4'd0, time_o}, {4'd0, 64'h1_0000_0100});
    wr(A_LDLO, 32'h200);
    wr(A_LDGO, 32'h0);
    chk(time_o == 64'h1_0000_0100, "R3 strobe bit0 clear ignored", {4'd0, time_o}, {4'd0, 64'h1_0000_0100});

    // R2: rate by step field
    wr(A_CTRL, 32'h21);
    rate(10, 64'd10, "R2 step 0");
    wr(A_STEP, 32'h3);
    rate(10, 64'd40, "R2 step 3");
    wr(A_STEP, 32'h7);
    rate(10, 64'd80, "R2 step 7");
    wr(A_STEP, 32'h0);

    // R5: trim every 4th tick
    wr(A_CORLO, 32'd4);
    rate(8, 64'd10, "R5 trim faster");
    wr(A_CTRL, 32'hA1);
    rate(8, 64'd6, "R5 trim slower");
    wr(A_STEP, 32'h2);
    rate(8, 64'd22, "R5 trim slower step 2");
    wr(A_CTRL, 32'h21);
    rate(8, 64'd26, "R5 trim faster step 2");

    // R6: zero interval disables trim
    wr(A_CORLO, 32'd0);
    rate(8, 64'd24, "R6 zero interval");

    // R2: disable holds
    wr(A_CTRL, 32'h20);
    rate(5, 64'd0, "R2 disabled holds");

    // R7: push while disabled and enabled
    push_evt();
    wr(A_PUSH, 32'h0);
    rate(3, 64'd0, "R7 push no time effect");
    wr(A_CTRL, 32'h21);
    repeat (3) @(negedge clk_i);
    push_evt();
    repeat (3) @(negedge clk_i);

    // R4 narrow wrap, R8 rollover
    wr(A_STEP, 32'h0);
    wr(A_CTRL, 32'h01);
    wr(A_LDHI, 32'h5);
    wr(A_LDLO, 32'hFFFF_FFF0);
    exp_q.push_back({4'd1, 64'h5_0000_0000});
    wr(A_LDGO, 32'h1);
    chk(time_o == 64'h5_FFFF_FFF0, "R3 load over counting", {4'd0, time_o}, {4'd0, 64'h5_FFFF_FFF0});
    repeat (30) @(negedge clk_i);
    chk(time_o == 64'h5_0000_000E, "R4 narrow wrap", {4'd0, time_o}, {4'd0, 64'h5_0000_000E});

    // R4 wide carry
    wr(A_CTRL, 32'h21);
    exp_q.push_back({4'd1, 64'h6_0000_0000});
    wr(A_LDGO, 32'h1);
    repeat (30) @(negedge clk_i);
    chk(time_o == 64'h6_0000_000E, "R4 wide carry", {4'd0, time_o}, {4'd0, 64'h6_0000_000E});

    // R8 half-rollover
    wr(A_LDHI, 32'h2);
    wr(A_LDLO, 32'h7FFF_FFF8);
    exp_q.push_back({4'd2, 64'h2_8000_0000});
    wr(A_LDGO, 32'h1);
    repeat (20) @(negedge clk_i);
    chk(time_o == 64'h2_8000_000C, "R8 half crossing", {4'd0, time_o}, {4'd0, 64'h2_8000_000C});

    // R9 push coincides with rollover
    wr(A_LDHI, 32'h0);
    wr(A_LDLO, 32'hFFFF_FFFF);
    wr(A_LDGO, 32'h1);
    exp_q.push_back({4'd0, 64'h0_FFFF_FFFF});
    exp_q.push_back({4'd1, 64'h1_0000_0000});
    wr(A_PUSH, 32'h1);
    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R9 all events seen", {36'd0, 32'(exp_q.size())}, '0);

    finish_run();
  end

endmodule